// File: doc/BRIEF.md
# Two-Stage Register Access Sequencer

This block is a bus master that turns single host requests into the pointer-then-data cycles needed by a two-channel serial controller. That controller sees only a control port and a data port. A request names a channel, a logical register number, a read, write or read-modify-write operation, write data and a flag that drops the trailing recovery gap. The sequencer issues one to four bus strobes. It keeps an idle gap of `GAP_CYCLES` clocks between strobes, which the integrator sets to cover at least 3.5 controller clock periods.

The controller's write-only registers cannot be read back. The sequencer therefore keeps a 16-entry byte shadow per channel and answers reads of those registers from the shadow without touching the bus. Register 7 has two meanings, selected by bit 0 of register 15. The sequencer tracks that select bit in the shadow and inserts a register-15 write only when the selection has to change. Two read registers exist on only one channel, so requests for them are steered to that channel. A read-modify-write works on a shadowed register: it combines the shadow value with a mask and a set pattern and writes the result back.

Logical register numbers: 0 to 15 name write registers 0 to 15. Numbers 16 to 31 name read register (number - 16). Number 32 names the option register that shares address 7.

Top module: `dual_chan_reg_sequencer`

## Requirements
- R1: `req_ready` is 1 out of reset and whenever idle. It is 0 from the cycle after a request is accepted until after the response. Each request gets exactly one `rsp_valid` pulse of one cycle.
- R2: Within a request, consecutive bus strobes are exactly `GAP_CYCLES`+1 cycles apart. The first strobe comes in the cycle after acceptance. Unless the skip flag is set, the response comes `GAP_CYCLES`+1 cycles after the last strobe.
- R3: With `req_nodelay`=1, the response comes in the cycle right after the last strobe.
- R4: A write to register 1-6, 10-13 or 15 issues two control-port writes: first the pointer (the register number), then the value. The value is stored in that channel's shadow.
- R5: A write to register 0 is one control-port write (`bus_port`=0). A write to register 8 is one data-port write (`bus_port`=1). Neither write changes any shadow entry, and logical number 32 still reads back its own last value after a register-8 write.
- R6: A write to register 9 sends and stores the value ANDed with 0x3F, in a single slot shared by both channels. A write to register 14 sends and stores the value ANDed with 0x1F.
- R7: A write to register 7 first writes register 15 with bit 0 cleared, and updates that shadow, but only when shadow bit 0 of register 15 is 1.
- R8: A write to number 32 first writes register 15 with bit 0 set, but only when that shadow bit is 0. It then writes pointer 7 and the value, and keeps the value in shadow slot 8.
- R9: A read of number 1-7, 9-15 or 32 makes no bus strobe. It returns the shadow value with `rsp_valid` in the cycle after acceptance.
- R10: A read of number 19 always uses channel A (`bus_chan`=0). A read of number 18 always uses channel B (`bus_chan`=1). Each is a pointer write of n-16 followed by a control-port read.
- R11: Number 16 is a single control-port read and number 24 a single data-port read. Numbers 17, 22, 23 and 26 are a pointer write followed by a control-port read. `rsp_rdata` is the byte on `bus_rdata` during the final read strobe.
- R12: A read-modify-write on a shadowed number writes (shadow AND `req_mask`) OR `req_set` through the normal write sequence. It returns the written byte, after any R6 masking, on `rsp_rdata`.
- R13: An undefined number responds with `rsp_err`=1 and makes no bus strobe. Undefined means: a write above 15 other than 32; a read of 0, 8, 20, 21, 25, 27-31 or above 32; a read-modify-write of 0, 8 or 16 and above other than 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this edge |
| req_chan | input | 1 | Channel, 0 = A, 1 = B |
| req_reg | input | 6 | Logical register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rmw | input | 1 | Read-modify-write (overrides `req_write`) |
| req_wdata | input | 8 | Write data |
| req_mask | input | 8 | AND mask for read-modify-write |
| req_set | input | 8 | OR pattern for read-modify-write |
| req_nodelay | input | 1 | Skip the trailing recovery gap |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Undefined register number |
| rsp_rdata | output | 8 | Read data or written byte |
| bus_stb | output | 1 | Bus access this cycle |
| bus_chan | output | 1 | Channel addressed |
| bus_port | output | 1 | 0 = control port, 1 = data port |
| bus_we | output | 1 | 1 = write access |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid during a read strobe |

## Verification
The assertions assume the host holds back the next request until `req_ready` returns, and that any request following one sent with the skip flag observes the recovery gap on its own. The gap check relaxes its spacing rule only across that one skipped gap. The bench sends each request only after seeing `req_ready` high at a falling edge and drops `req_valid` right after acceptance. A behavioural controller model beside the bench returns read bytes built from the last control write. This lets the bench predict every read result without knowing the sequencer's internals.

// File: rtl/dual_chan_reg_sequencer.sv
module dual_chan_reg_sequencer #(
  parameter int GAP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_chan,
  input  logic [5:0] req_reg,
  input  logic       req_write,
  input  logic       req_rmw,
  input  logic [7:0] req_wdata,
  input  logic [7:0] req_mask,
  input  logic [7:0] req_set,
  input  logic       req_nodelay,
  output logic       rsp_valid,
  output logic       rsp_err,
  output logic [7:0] rsp_rdata,
  output logic       bus_stb,
  output logic       bus_chan,
  output logic       bus_port,
  output logic       bus_we,
  output logic [7:0] bus_wdata,
  input  logic [7:0] bus_rdata
);

  localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam int IW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GLD = GW'(GAP_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE_P, S_PRE_D, S_PTR, S_MAIN, S_GAP, S_RESP} st_t;

  st_t        state, c_after;
  logic [GW-1:0] gap_cnt;
  logic [5:0] c_reg;
  logic       c_chan, c_port, c_we, c_ptr_en, c_skip, c_err;
  logic [3:0] c_ptr;
  logic [7:0] c_data, c_pre_val;
  logic [7:0] shadow [2][16];

  // request decode
  logic       shadowable, rd_bus, wr_ok, bad, sh_ch, rd_ch, pre;
  logic [3:0] sh_slot;
  logic [7:0] sh_rd, sh15, merged, wr_val;

  assign shadowable = (req_reg >= 6'd1 && req_reg <= 6'd7) ||
                      (req_reg >= 6'd9 && req_reg <= 6'd15) || req_reg == 6'd32;
  assign rd_bus = req_reg inside {6'd16, 6'd17, 6'd18, 6'd19, 6'd22, 6'd23, 6'd24, 6'd26};
  assign wr_ok  = req_reg < 6'd16 || req_reg == 6'd32;
  assign bad    = req_rmw ? !shadowable : req_write ? !wr_ok : !(shadowable || rd_bus);
  assign sh_ch   = (req_reg == 6'd9) ? 1'b0 : req_chan;
  assign sh_slot = (req_reg == 6'd32) ? 4'd8 : req_reg[3:0];
  assign sh_rd   = shadow[sh_ch][sh_slot];
  assign sh15    = shadow[req_chan][15];
  assign merged  = req_rmw ? ((sh_rd & req_mask) | req_set) : req_wdata;
  assign wr_val  = (req_reg == 6'd9)  ? (merged & 8'h3F) :
                   (req_reg == 6'd14) ? (merged & 8'h1F) : merged;
  assign rd_ch   = (req_reg == 6'd19) ? 1'b0 : (req_reg == 6'd18) ? 1'b1 : req_chan;
  assign pre     = (req_reg == 6'd7 && sh15[0]) || (req_reg == 6'd32 && !sh15[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      c_after   <= S_IDLE;
      gap_cnt   <= '0;
      c_reg     <= '0;
      c_chan    <= 1'b0;
      c_port    <= 1'b0;
      c_we      <= 1'b0;
      c_ptr_en  <= 1'b0;
      c_skip    <= 1'b0;
      c_err     <= 1'b0;
      c_ptr     <= '0;
      c_data    <= '0;
      c_pre_val <= '0;
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 16; i++) shadow[c][i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          c_reg  <= req_reg;
          c_skip <= req_nodelay;
          c_err  <= 1'b0;
          if (bad) begin
            c_err <= 1'b1;
            state <= S_RESP;
          end else if (!req_write && !req_rmw && shadowable) begin
            c_data <= sh_rd;
            state  <= S_RESP;
          end else if (!req_write && !req_rmw) begin
            c_chan   <= rd_ch;
            c_we     <= 1'b0;
            c_port   <= (req_reg == 6'd24);
            c_ptr_en <= !(req_reg == 6'd16 || req_reg == 6'd24);
            c_ptr    <= req_reg[3:0];
            state    <= (req_reg == 6'd16 || req_reg == 6'd24) ? S_MAIN : S_PTR;
          end else begin
            c_chan    <= req_chan;
            c_we      <= 1'b1;
            c_port    <= (req_reg == 6'd8);
            c_ptr_en  <= !(req_reg == 6'd0 || req_reg == 6'd8);
            c_ptr     <= (req_reg == 6'd32) ? 4'd7 : req_reg[3:0];
            c_data    <= wr_val;
            c_pre_val <= sh15 ^ 8'h01;
            if (pre) shadow[req_chan][15] <= sh15 ^ 8'h01;
            if (req_reg != 6'd0 && req_reg != 6'd8) shadow[sh_ch][sh_slot] <= wr_val;
            state <= pre ? S_PRE_P :
                     (req_reg == 6'd0 || req_reg == 6'd8) ? S_MAIN : S_PTR;
          end
        end
        S_PRE_P: begin state <= S_GAP; gap_cnt <= GLD; c_after <= S_PRE_D; end
        S_PRE_D: begin state <= S_GAP; gap_cnt <= GLD; c_after <= S_PTR; end
        S_PTR:   begin state <= S_GAP; gap_cnt <= GLD; c_after <= S_MAIN; end
        S_MAIN: begin
          if (!c_we) c_data <= bus_rdata;
          if (c_skip) state <= S_RESP;
          else begin state <= S_GAP; gap_cnt <= GLD; c_after <= S_RESP; end
        end
        S_GAP: if (gap_cnt == '0) state <= c_after;
               else gap_cnt <= gap_cnt - 1'b1;
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign bus_stb   = state inside {S_PRE_P, S_PRE_D, S_PTR, S_MAIN};
  assign bus_chan  = c_chan;
  assign bus_port  = (state == S_MAIN) && c_port;
  assign bus_we    = (state == S_MAIN) ? c_we : 1'b1;
  assign rsp_valid = (state == S_RESP);
  assign rsp_err   = rsp_valid && c_err;
  assign rsp_rdata = c_data;

  always_comb begin
    case (state)
      S_PRE_P: bus_wdata = 8'd15;
      S_PRE_D: bus_wdata = c_pre_val;
      S_PTR:   bus_wdata = {4'd0, c_ptr};
      S_MAIN:  bus_wdata = c_we ? c_data : 8'd0;
      default: bus_wdata = 8'd0;
    endcase
  end

  // gap tracking for the spacing check
  logic [IW-1:0] idle_cnt;
  logic          gap_owed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      gap_owed <= 1'b0;
    end else if (bus_stb) begin
      idle_cnt <= '0;
      gap_owed <= !(state == S_MAIN && c_skip);
    end else if (idle_cnt != IW'(GAP_CYCLES)) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  p_gap_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && gap_owed) |-> (idle_cnt >= IW'(GAP_CYCLES)));
  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |-> !req_ready);
  p_err_nobus_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && $past(req_ready)));
  p_pending_chan_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && c_reg == 6'd19) |-> !bus_chan);
  p_vector_chan_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && c_reg == 6'd18) |-> bus_chan);
  p_master_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && bus_we && state == S_MAIN && c_reg == 6'd9) |-> (bus_wdata[7:6] == 2'b00));

endmodule

// File: tb/dual_chan_reg_sequencer_bench.sv
`timescale 1ns/1ps
module dual_chan_reg_sequencer_bench;
  localparam int GAP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_chan = 1'b0, req_write = 1'b0, req_rmw = 1'b0, req_nodelay = 1'b0;
  logic [5:0] req_reg = '0;
  logic [7:0] req_wdata = '0, req_mask = '0, req_set = '0;
  logic       req_ready, rsp_valid, rsp_err;
  logic [7:0] rsp_rdata;
  logic       bus_stb, bus_chan, bus_port, bus_we;
  logic [7:0] bus_wdata, bus_rdata;

  dual_chan_reg_sequencer #(.GAP_CYCLES(GAP)) u_dual_chan_reg_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_reg(req_reg), .req_write(req_write), .req_rmw(req_rmw),
    .req_wdata(req_wdata), .req_mask(req_mask), .req_set(req_set), .req_nodelay(req_nodelay),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_stb(bus_stb), .bus_chan(bus_chan), .bus_port(bus_port), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // controller model: reads echo the last control-port write
  logic [7:0] lastw [2];
  initial begin lastw[0] = '0; lastw[1] = '0; end
  always @(posedge clk) if (bus_stb && !bus_port && bus_we) lastw[bus_chan] <= bus_wdata;
  assign bus_rdata = bus_port ? (8'hC0 | {7'd0, bus_chan})
                              : {2'b01, bus_chan, 1'b0, lastw[bus_chan][3:0]};

  // bus log
  int   log_n = 0;
  int   log_cyc [8];
  logic log_ch [8], log_pt [8], log_we [8];
  logic [7:0] log_d [8];
  always @(negedge clk) if (bus_stb && log_n < 8) begin
    log_cyc[log_n] = cyc; log_ch[log_n] = bus_chan; log_pt[log_n] = bus_port;
    log_we[log_n] = bus_we; log_d[log_n] = bus_wdata; log_n = log_n + 1;
  end

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // reference model
  logic [7:0] msh [2][16];
  int   e_n;
  logic e_ch [4], e_pt [4], e_we [4];
  logic [7:0] e_d [4];
  logic e_err, chk_rd;
  logic [7:0] e_rd;

  task automatic add(input logic c, input logic p, input logic w, input logic [7:0] d);
    e_ch[e_n] = c; e_pt[e_n] = p; e_we[e_n] = w; e_d[e_n] = d; e_n++;
  endtask

  function automatic bit shdw(input logic [5:0] rg);
    return (rg >= 1 && rg <= 7) || (rg >= 9 && rg <= 15) || rg == 32;
  endfunction

  task automatic wpath(input logic c, input logic [5:0] rg, input logic [7:0] v);
    logic [7:0] vm;
    vm = (rg == 9) ? (v & 8'h3F) : (rg == 14) ? (v & 8'h1F) : v;
    e_rd = vm;
    if (rg == 0) add(c, 1'b0, 1'b1, vm);
    else if (rg == 8) add(c, 1'b1, 1'b1, vm);
    else begin
      if (rg == 7 && msh[c][15][0]) begin
        add(c, 1'b0, 1'b1, 8'd15); msh[c][15] = msh[c][15] & 8'hFE; add(c, 1'b0, 1'b1, msh[c][15]);
      end
      if (rg == 32 && !msh[c][15][0]) begin
        add(c, 1'b0, 1'b1, 8'd15); msh[c][15] = msh[c][15] | 8'h01; add(c, 1'b0, 1'b1, msh[c][15]);
      end
      add(c, 1'b0, 1'b1, (rg == 32) ? 8'd7 : {4'd0, rg[3:0]});
      add(c, 1'b0, 1'b1, vm);
      msh[(rg == 9) ? 0 : c][(rg == 32) ? 8 : rg[3:0]] = vm;
    end
  endtask

  function automatic string tagof(input logic [5:0] rg, input logic wr, input logic rmw, input logic err);
    if (err) return "R13";
    if (rmw) return "R12";
    if (wr) begin
      if (rg == 0 || rg == 8) return "R5";
      if (rg == 9 || rg == 14) return "R6";
      if (rg == 7) return "R7";
      if (rg == 32) return "R8";
      return "R4";
    end
    if (shdw(rg)) return "R9";
    if (rg == 18 || rg == 19) return "R10";
    return "R11";
  endfunction

  task automatic do_req(input logic c, input logic [5:0] rg, input logic wr, input logic rmw,
                        input logic [7:0] d, input logic [7:0] m, input logic [7:0] s, input logic skip);
    logic [7:0] shv;
    logic ec;
    int acc, rc, exp_rc;
    logic got_err;
    logic [7:0] got_rd;
    string tg;
    e_n = 0; e_err = 1'b0; chk_rd = 1'b0; e_rd = '0;
    shv = shdw(rg) ? msh[(rg == 9) ? 0 : c][(rg == 32) ? 8 : rg[3:0]] : 8'd0;
    if (rmw) begin
      if (!shdw(rg)) e_err = 1'b1; else begin wpath(c, rg, (shv & m) | s); chk_rd = 1'b1; end
    end else if (wr) begin
      if (!(rg < 16 || rg == 32)) e_err = 1'b1; else wpath(c, rg, d);
    end else if (shdw(rg)) begin
      chk_rd = 1'b1; e_rd = shv;
    end else if (rg == 16) begin
      add(c, 1'b0, 1'b0, 8'd0); chk_rd = 1'b1; e_rd = {2'b01, c, 1'b0, lastw[c][3:0]};
    end else if (rg == 24) begin
      add(c, 1'b1, 1'b0, 8'd0); chk_rd = 1'b1; e_rd = 8'hC0 | {7'd0, c};
    end else if (rg inside {6'd17, 6'd18, 6'd19, 6'd22, 6'd23, 6'd26}) begin
      ec = (rg == 19) ? 1'b0 : (rg == 18) ? 1'b1 : c;
      add(ec, 1'b0, 1'b1, {4'd0, rg[3:0]}); add(ec, 1'b0, 1'b0, 8'd0);
      chk_rd = 1'b1; e_rd = {2'b01, ec, 1'b0, rg[3:0]};
    end else e_err = 1'b1;
    tg = tagof(rg, wr, rmw, e_err);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_chan = c; req_reg = rg; req_write = wr; req_rmw = rmw;
    req_wdata = d; req_mask = m; req_set = s; req_nodelay = skip;
    req_valid = 1'b1; log_n = 0;
    @(posedge clk); #1;
    acc = cyc; req_valid = 1'b0;
    rc = -1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (k == 0 && !rsp_valid) check(!req_ready, "R1", "ready while busy", req_ready, 0);
      if (rsp_valid) begin rc = cyc; got_err = rsp_err; got_rd = rsp_rdata; break; end
    end
    check(rc >= 0, "R1", "response seen", rc, acc);
    if (rc < 0) return;
    check(got_err == e_err, tg, $sformatf("error flag reg %0d", rg), got_err, e_err);
    check(log_n == e_n, tg, $sformatf("strobe count reg %0d", rg), log_n, e_n);
    for (int i = 0; i < e_n && i < log_n; i++) begin
      check(log_ch[i] == e_ch[i], tg, $sformatf("chan reg %0d step %0d", rg, i), log_ch[i], e_ch[i]);
      check(log_pt[i] == e_pt[i] && log_we[i] == e_we[i], tg, $sformatf("port/we reg %0d step %0d", rg, i),
            {log_pt[i], log_we[i]}, {e_pt[i], e_we[i]});
      if (e_we[i]) check(log_d[i] == e_d[i], tg, $sformatf("wdata reg %0d step %0d", rg, i), log_d[i], e_d[i]);
      check(log_cyc[i] == acc + i * (GAP + 1), "R2", $sformatf("strobe time reg %0d step %0d", rg, i),
            log_cyc[i] - acc, i * (GAP + 1));
    end
    exp_rc = (e_n == 0) ? acc : acc + (e_n - 1) * (GAP + 1) + (skip ? 1 : GAP + 1);
    if (e_n == 0) check(rc == exp_rc, (e_err ? "R13" : "R9"), $sformatf("response time reg %0d", rg), rc - acc, 0);
    else if (skip) check(rc == exp_rc, "R3", $sformatf("response time reg %0d", rg), rc - acc, exp_rc - acc);
    else check(rc == exp_rc, "R2", $sformatf("response time reg %0d", rg), rc - acc, exp_rc - acc);
    if (chk_rd && !e_err) check(got_rd == e_rd, tg, $sformatf("rdata reg %0d", rg), got_rd, e_rd);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int i = 0; i < 16; i++) msh[c][i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    check(rsp_valid == 1'b0 && bus_stb == 1'b0, "R1", "quiet in reset", {rsp_valid, bus_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    // sweep writes and readbacks over every number, both channels
    for (int c = 0; c < 2; c++)
      for (int rg = 0; rg < 41; rg++) begin
        do_req(c[0], rg[5:0], 1'b1, 1'b0, 8'(rg * 29 + c * 7 + 5), 8'h00, 8'h00, rg[0]);
        do_req(c[0], rg[5:0], 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, rg[1]);
      end
    // R7/R8 alias toggling both ways
    for (int k = 0; k < 4; k++) begin
      do_req(k[0], 6'd32, 1'b1, 1'b0, 8'(8'h5A + k), 8'h00, 8'h00, 1'b0);
      do_req(k[0], 6'd32, 1'b1, 1'b0, 8'(8'h11 + k), 8'h00, 8'h00, 1'b1);
      do_req(k[0], 6'd7,  1'b1, 1'b0, 8'(8'hA5 + k), 8'h00, 8'h00, 1'b0);
      do_req(k[0], 6'd7,  1'b1, 1'b0, 8'(8'h3C + k), 8'h00, 8'h00, 1'b0);
      do_req(k[0], 6'd15, 1'b1, 1'b0, 8'(8'h81 + 2 * k), 8'h00, 8'h00, 1'b0);
      do_req(k[0], 6'd7,  1'b1, 1'b0, 8'(8'h66 + k), 8'h00, 8'h00, 1'b0);
    end
    // R5: data-port write leaves slot of number 32 intact
    do_req(1'b0, 6'd32, 1'b1, 1'b0, 8'h5A, 8'h00, 8'h00, 1'b0);
    do_req(1'b0, 6'd8,  1'b1, 1'b0, 8'h33, 8'h00, 8'h00, 1'b0);
    do_req(1'b0, 6'd32, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0);
    // R6: shared register-9 slot across channels
    do_req(1'b1, 6'd9, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 1'b0);
    do_req(1'b0, 6'd9, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0);
    do_req(1'b0, 6'd14, 1'b1, 1'b0, 8'hEE, 8'h00, 8'h00, 1'b0);
    // R12: read-modify-write sweep
    for (int c = 0; c < 2; c++)
      for (int rg = 0; rg < 41; rg++) begin
        do_req(c[0], rg[5:0], 1'b0, 1'b1, 8'h00, 8'(8'hF0 ^ (rg * 13)), 8'(rg * 5 + c), rg[2]);
        if (shdw(rg[5:0])) do_req(c[0], rg[5:0], 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0);
      end
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule